// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block takes a single-rank SDRAM from power-up to a usable state and then keeps its contents alive. After reset it holds the command bus idle for a programmable pause. It then closes every bank and issues a counted series of auto-refresh commands. Last, it writes the mode register with the chosen CAS latency, burst length and wrap order. Once the mode register settles, it raises a ready flag and hands the bus to a refresh scheduler. That scheduler issues one auto-refresh per refresh interval and can hold two owed refreshes at most.

A level-sensitive request input puts the device into self refresh and takes it out again. Entry is only taken from the idle state when no refresh is owed. Exit raises the clock-enable pin. The exit is counted from the second rising edge after that, and a full row-cycle time must then pass before any command. A stay in self refresh that outlasts the refresh interval leaves refreshes owed. Those are paid back as back-to-back auto-refreshes. The activate-to-command delay is published as a package constant, `TRCD_CLKS`, for the downstream command block.

Top module: `sdr_power_refresh_seq`

## Requirements
- R1: While reset is high and on the first clock after it, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), CKE high, ready low and refresh_busy low.
- R2: After reset is released, only NOP appears on the command pins for at least PWRUP_CLKS clock cycles.
- R3: The start-up commands come in this order and nothing else is issued between them: one precharge (0010) with address bit 10 high and the other address bits low, then exactly INIT_REFS auto-refreshes (0001), then one mode register write (0000). The mode register write never happens again.
- R4: The first auto-refresh follows the precharge after exactly tRP cycles. tRP is 2 when SLOW_GRADE is 0 and 3 when it is 1.
- R5: Consecutive auto-refreshes during start-up are exactly TRC_CLKS cycles apart. The mode register write follows the last one after exactly TRC_CLKS cycles.
- R6: During the mode register write, the bank address is zero. Address bits [2:0] hold log2(BURST_LEN), bit 3 holds the wrap order (1 = interleave), bits [6:4] hold the CAS latency, and all higher bits are zero.
- R7: ready rises exactly TMRD_CLKS cycles after the mode register write.
- R8: In steady state with no self-refresh request, auto-refreshes with CKE high come exactly REFI_CLKS cycles apart. Each is issued with ready and refresh_busy high.
- R9: When two refreshes are owed, they are issued back to back, exactly TRC_CLKS apart. No more than two are ever owed, so a recovery run holds at most three consecutive TRC_CLKS-spaced auto-refreshes.
- R10: Self-refresh entry is code 0001 with CKE driven low on the same edge. It comes at least TRC_CLKS+1 cycles after the last auto-refresh. While CKE stays low, the command is NOP, ready is low and refresh_busy is high.
- R11: When the request drops, CKE rises. The next command comes no earlier than TRC_CLKS+2 cycles after the CKE rise, and ready is high by then.
- R12: A self-refresh request made before ready is high is ignored. The start-up sequence runs unchanged with CKE high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_req | input | 1 | Level request to enter (high) or leave (low) self refresh |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_cke | output | 1 | Clock enable |
| sdr_addr | output | ADDR_W | Address bus |
| sdr_ba | output | BA_W | Bank address |
| ready | output | 1 | Start-up done and not in self refresh |
| refresh_busy | output | 1 | Auto-refresh or its wait in progress, or in self refresh |

## Verification
The hardest case to reach from the ports is the refresh overrun. In normal running an owed refresh is always served long before the next interval ends, so two are never owed at once. The bench gets there by holding the device in self refresh for longer than two refresh intervals, while the interval counter keeps running. On exit, the auto-refreshes must come in a back-to-back pair, and the run must stop at the cap. A sweep over several self-refresh lengths and entry phases also covers stays shorter than one interval, where no recovery pair is due.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    // Activate-to-column-command delay offered to the downstream command block
    localparam int TRCD_CLKS = 2;

    typedef enum logic [3:0] {
        ST_BOOT,
        ST_PWR_WAIT,
        ST_PRE,
        ST_PRE_WAIT,
        ST_IREF,
        ST_IREF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_IDLE,
        ST_REF,
        ST_REF_WAIT,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_SR_EXIT_WAIT
    } seq_state_e;

    // Everything the pin stage registers besides the address buses
    typedef struct packed {
        sdr_cmd_e cmd;
        logic     cke;
        logic     ready;
        logic     busy;
    } pin_word_t;

    function automatic int trp_for_grade(input bit slow);
        return slow ? 3 : 2;
    endfunction

    function automatic logic [2:0] burst_code(input int bl);
        case (bl)
            1:       return 3'd0;
            2:       return 3'd1;
            4:       return 3'd2;
            8:       return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [15:0] mode_word(input int cl, input int bl, input bit ilv);
        logic [15:0] w;
        w      = '0;
        w[2:0] = burst_code(bl);
        w[3]   = ilv;
        w[6:4] = 3'(cl);
        return w;
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5
    timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/sdr_refresh_tracker.sv
module sdr_refresh_tracker #(
    parameter int REFI_CLKS = 1560
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       serve,
    output logic [1:0] pending
);
    localparam int IW = (REFI_CLKS > 1) ? $clog2(REFI_CLKS) : 1;
    localparam logic [IW-1:0] LAST = IW'(REFI_CLKS - 1);

    logic [IW-1:0] ivl_q;
    logic          tick;
    logic [1:0]    pend_q, pend_d;

    always_ff @(posedge clk) begin
        if (rst || !en)        ivl_q <= '0;
        else if (ivl_q == LAST) ivl_q <= '0;
        else                   ivl_q <= ivl_q + 1'b1;
    end

    assign tick = en && (ivl_q == LAST);

    always_comb begin
        pend_d = pend_q;
        unique case ({tick, serve})
            2'b10:   pend_d = (pend_q == 2'd2) ? 2'd2 : pend_q + 2'd1;
            2'b01:   pend_d = pend_q - 2'd1;
            default: pend_d = pend_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pending = pend_q;

    // R9
    pending_cap_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q != 2'd3);
    // R8
    serve_has_work_chk: assert property (@(posedge clk) disable iff (rst)
        serve |-> (pend_q != 2'd0));
endmodule

// File: rtl/sdr_pin_stage.sv
module sdr_pin_stage
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_word_t         word_d,
    input  logic [ADDR_W-1:0] addr_d,
    output pin_word_t         word_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BA_W-1:0]   ba_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '{cmd: CMD_NOP, cke: 1'b1, ready: 1'b0, busy: 1'b0};
            addr_q <= '0;
            ba_q   <= '0;
        end else begin
            word_q <= word_d;
            addr_q <= addr_d;
            ba_q   <= '0;
        end
    end

    // R10
    cke_fall_with_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(word_q.cke) |-> (word_q.cmd == CMD_AREF));
    // R10
    nop_while_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_q.cke && $past(!word_q.cke)) |-> (word_q.cmd == CMD_NOP));
    // R11
    ready_needs_clock_chk: assert property (@(posedge clk) disable iff (rst)
        word_q.ready |-> word_q.cke);
    // R3
    precharge_all_chk: assert property (@(posedge clk) disable iff (rst)
        (word_q.cmd == CMD_PRE) |-> addr_q[10]);
endmodule

// File: rtl/sdr_power_refresh_seq.sv
module sdr_power_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int PWRUP_CLKS  = 10000,
    parameter int INIT_REFS   = 8,
    parameter int TRC_CLKS    = 7,
    parameter int TMRD_CLKS   = 2,
    parameter int REFI_CLKS   = 1560,
    parameter bit SLOW_GRADE  = 1'b0,
    parameter int CAS_LAT     = 2,
    parameter int BURST_LEN   = 4,
    parameter bit WRAP_ILV    = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sr_req,
    output logic              sdr_cs_n,
    output logic              sdr_ras_n,
    output logic              sdr_cas_n,
    output logic              sdr_we_n,
    output logic              sdr_cke,
    output logic [ADDR_W-1:0] sdr_addr,
    output logic [BA_W-1:0]   sdr_ba,
    output logic              ready,
    output logic              refresh_busy
);
    localparam int TRP_CLKS = trp_for_grade(SLOW_GRADE);
    localparam int SPAN     = PWRUP_CLKS + TRC_CLKS + TRP_CLKS + TMRD_CLKS + 4;
    localparam int CW       = $clog2(SPAN + 1);
    localparam int RW       = $clog2(INIT_REFS + 1);

    localparam logic [CW-1:0] LD_PWRUP = CW'(PWRUP_CLKS - 2);
    localparam logic [CW-1:0] LD_TRP   = CW'(TRP_CLKS - 2);
    localparam logic [CW-1:0] LD_TRC   = CW'(TRC_CLKS - 2);
    localparam logic [CW-1:0] LD_TMRD  = CW'(TMRD_CLKS - 2);
    localparam logic [CW-1:0] LD_EXIT  = CW'(TRC_CLKS);
    localparam logic [15:0]   MODE_W   = mode_word(CAS_LAT, BURST_LEN, WRAP_ILV);

    seq_state_e        st_q, st_d;
    logic              tmr_load, tmr_done;
    logic [CW-1:0]     tmr_val;
    logic [RW-1:0]     refs_left_q;
    logic              init_done_q;
    logic              serve;
    logic [1:0]        pending;
    pin_word_t         word_d, word_q;
    logic [ADDR_W-1:0] addr_d;

    sdr_wait_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdr_refresh_tracker #(.REFI_CLKS(REFI_CLKS)) u_track (
        .clk(clk), .rst(rst), .en(init_done_q), .serve(serve), .pending(pending)
    );

    // Sequencing decisions
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        serve    = 1'b0;
        unique case (st_q)
            ST_BOOT:      begin tmr_load = 1'b1; tmr_val = LD_PWRUP; st_d = ST_PWR_WAIT; end
            ST_PWR_WAIT:  if (tmr_done) st_d = ST_PRE;
            ST_PRE:       begin tmr_load = 1'b1; tmr_val = LD_TRP; st_d = ST_PRE_WAIT; end
            ST_PRE_WAIT:  if (tmr_done) st_d = ST_IREF;
            ST_IREF:      begin tmr_load = 1'b1; tmr_val = LD_TRC; st_d = ST_IREF_WAIT; end
            ST_IREF_WAIT: if (tmr_done) st_d = (refs_left_q != '0) ? ST_IREF : ST_MRS;
            ST_MRS:       begin tmr_load = 1'b1; tmr_val = LD_TMRD; st_d = ST_MRS_WAIT; end
            ST_MRS_WAIT:  if (tmr_done) st_d = ST_IDLE;
            ST_IDLE: begin
                if (pending != 2'd0) st_d = ST_REF;
                else if (sr_req)     st_d = ST_SR_ENTER;
            end
            ST_REF: begin
                serve = 1'b1; tmr_load = 1'b1; tmr_val = LD_TRC; st_d = ST_REF_WAIT;
            end
            ST_REF_WAIT:  if (tmr_done) st_d = (pending != 2'd0) ? ST_REF : ST_IDLE;
            ST_SR_ENTER:  st_d = ST_SR_HOLD;
            ST_SR_HOLD:   if (!sr_req) st_d = ST_SR_EXIT;
            ST_SR_EXIT:   begin tmr_load = 1'b1; tmr_val = LD_EXIT; st_d = ST_SR_EXIT_WAIT; end
            ST_SR_EXIT_WAIT: if (tmr_done) st_d = ST_IDLE;
            default:      st_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_BOOT;
            refs_left_q <= RW'(INIT_REFS);
            init_done_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IREF) refs_left_q <= refs_left_q - 1'b1;
            if (st_q == ST_MRS_WAIT && tmr_done) init_done_q <= 1'b1;
        end
    end

    // Pin values for the current state
    always_comb begin
        word_d = '{cmd: CMD_NOP, cke: 1'b1, ready: 1'b0, busy: 1'b0};
        addr_d = '0;
        unique case (st_q)
            ST_PRE:  begin word_d.cmd = CMD_PRE; addr_d[10] = 1'b1; end
            ST_IREF: word_d.cmd = CMD_AREF;
            ST_MRS:  begin word_d.cmd = CMD_MRS; addr_d = MODE_W[ADDR_W-1:0]; end
            ST_IDLE: word_d.ready = 1'b1;
            ST_REF:  begin word_d.cmd = CMD_AREF; word_d.ready = 1'b1; word_d.busy = 1'b1; end
            ST_REF_WAIT: begin word_d.ready = 1'b1; word_d.busy = 1'b1; end
            ST_SR_ENTER: begin word_d.cmd = CMD_AREF; word_d.cke = 1'b0; word_d.busy = 1'b1; end
            ST_SR_HOLD:  begin word_d.cke = 1'b0; word_d.busy = 1'b1; end
            ST_SR_EXIT, ST_SR_EXIT_WAIT: word_d.busy = 1'b1;
            default: ;
        endcase
    end

    sdr_pin_stage #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk(clk), .rst(rst), .word_d(word_d), .addr_d(addr_d),
        .word_q(word_q), .addr_q(sdr_addr), .ba_q(sdr_ba)
    );

    assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = word_q.cmd;
    assign sdr_cke      = word_q.cke;
    assign ready        = word_q.ready;
    assign refresh_busy = word_q.busy;

    // R3
    mrs_once_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MRS) |-> !init_done_q);
    // R10
    entry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SR_ENTER) |-> ($past(pending) == 2'd0 && $past(st_q) == ST_IDLE));
    // R12
    no_sleep_before_init_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SR_ENTER) |-> init_done_q);
endmodule

// File: tb/tb_sdr_power_refresh_seq.sv
module tb_sdr_power_refresh_seq;
    localparam int AW = 13, BW = 2;
    localparam int PWRUP = 40, NREF = 8, TRC = 5, TMRD = 2, REFI = 60;
    localparam bit SLOW = 1'b1;
    localparam int CL = 3, BL = 4;
    localparam bit ILV = 1'b1;
    localparam int TRP = SLOW ? 3 : 2;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_AREF = 4'b0001, C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sr_req = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, ready, busy;
    logic [AW-1:0] addr;
    logic [BW-1:0] ba;

    always #4 clk = ~clk;

    sdr_power_refresh_seq #(
        .ADDR_W(AW), .BA_W(BW), .PWRUP_CLKS(PWRUP), .INIT_REFS(NREF), .TRC_CLKS(TRC),
        .TMRD_CLKS(TMRD), .REFI_CLKS(REFI), .SLOW_GRADE(SLOW), .CAS_LAT(CL),
        .BURST_LEN(BL), .WRAP_ILV(ILV)
    ) dut (
        .clk(clk), .rst(rst), .sr_req(sr_req),
        .sdr_cs_n(cs_n), .sdr_ras_n(ras_n), .sdr_cas_n(cas_n), .sdr_we_n(we_n),
        .sdr_cke(cke), .sdr_addr(addr), .sdr_ba(ba), .ready(ready), .refresh_busy(busy)
    );

    int cyc = 0;
    int n_run = 0, n_fail = 0;
    int last_aref = 0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] cmd4();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_cmd(output int t, output logic [3:0] c);
        do @(negedge clk); while (cmd4() == C_NOP);
        t = cyc;
        c = cmd4();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t, tp, t0, tck;
        int bad;
        logic [3:0] c;
        logic [AW-1:0] exp_mode;
        int durs[4]  = '{8, 40, 150, 260};
        int phase[4] = '{0, 13, 29, 47};

        exp_mode = '0;
        exp_mode[2:0] = 3'($clog2(BL));
        exp_mode[3]   = ILV;
        exp_mode[6:4] = 3'(CL);

        // R1 and R12: reset values; request sleep during start-up
        sr_req = 1'b1;
        repeat (3) @(negedge clk);
        chk(cmd4() == C_NOP && cke && !ready && !busy, "R1 reset pins", {cmd4(), cke, ready, busy}, {C_NOP, 3'b100});
        rst = 1'b0;
        t0 = cyc;
        @(negedge clk);
        chk(cmd4() == C_NOP && cke && !ready && !busy, "R1 first cycle", {cmd4(), cke, ready, busy}, {C_NOP, 3'b100});

        // R2 / R3: precharge after the pause
        next_cmd(t, c);
        chk(t - t0 >= PWRUP, "R2 power-up pause", t - t0, PWRUP);
        chk(c == C_PRE && addr == AW'(1 << 10) && cke, "R3 precharge all", {c, addr}, {C_PRE, AW'(1 << 10)});
        tp = t;

        // R3 / R4 / R5 / R12: counted refreshes
        bad = 0;
        for (int i = 0; i < NREF; i++) begin
            next_cmd(t, c);
            if (c != C_AREF || !cke) bad++;
            if (i == 0) chk(t - tp == TRP, "R4 tRP gap", t - tp, TRP);
            else if (t - tp != TRC) bad++;
            tp = t;
        end
        chk(bad == 0, "R3 R5 R12 init refresh series", bad, 0);

        next_cmd(t, c);
        chk(c == C_MRS && cke, "R3 mode write follows", c, C_MRS);
        chk(t - tp == TRC, "R5 gap to mode write", t - tp, TRC);
        chk(addr == exp_mode && ba == '0, "R6 mode word", addr, exp_mode);
        chk(!ready, "R7 not ready at mode write", ready, 0);
        sr_req = 1'b0;
        tp = t;
        while (!ready) @(negedge clk);
        chk(cyc - tp == TMRD, "R7 ready delay", cyc - tp, TMRD);

        // R8: periodic refresh
        next_cmd(t, c);
        tp = t;
        for (int i = 0; i < 3; i++) begin
            next_cmd(t, c);
            chk(c == C_AREF && cke && ready && busy, "R8 periodic refresh pins", {c, cke, ready, busy}, {C_AREF, 3'b111});
            chk(t - tp == REFI, "R8 refresh interval", t - tp, REFI);
            tp = t;
        end
        last_aref = tp;

        // R9 / R10 / R11: self-refresh sweep
        for (int k = 0; k < 4; k++) begin
            repeat (phase[k]) @(negedge clk);
            sr_req = 1'b1;
            forever begin
                next_cmd(t, c);
                if (!cke) break;
                last_aref = t;
            end
            chk(c == C_AREF, "R10 entry code", c, C_AREF);
            chk(t - last_aref >= TRC + 1, "R10 entry after refresh", t - last_aref, TRC + 1);
            @(negedge clk);
            chk(!ready && busy, "R10 flags asleep", {ready, busy}, 2'b01);
            bad = 0;
            for (int j = 0; j < durs[k]; j++) begin
                @(negedge clk);
                if (cke || cmd4() != C_NOP) bad++;
            end
            chk(bad == 0, "R10 quiet while asleep", bad, 0);
            sr_req = 1'b0;
            while (!cke) @(negedge clk);
            tck = cyc;
            next_cmd(t, c);
            chk(c == C_AREF && cke, "R11 first command after exit", c, C_AREF);
            chk(t - tck >= TRC + 2, "R11 exit wait", t - tck, TRC + 2);
            chk(ready, "R11 ready after exit", ready, 1);
            last_aref = t;
            if (durs[k] > 2 * REFI) begin
                int run;
                next_cmd(tp, c);
                chk(c == C_AREF && tp - t == TRC, "R9 recovery pair", tp - t, TRC);
                run = 2;
                for (int j = 0; j < 4; j++) begin
                    t = tp;
                    next_cmd(tp, c);
                    if (tp - t == TRC) run++;
                    else break;
                end
                chk(run <= 3, "R9 owed refresh cap", run, 3);
                last_aref = tp;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule